// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a multi-cycle processor, built as a microprogrammed sequencer. A microaddress register selects one word from a constant microcode store. Each word has two parts. The first is a 16-bit datapath control vector, which is driven straight out. The second is a 2-bit sequencing code that tells the next-address logic how to form the following microaddress.

The next microaddress comes from one of four sources:

- the current microaddress plus one;
- a first opcode lookup table, used at the decode step;
- a second opcode lookup table, used once the memory address is known;
- microaddress zero, the fetch entry.

The microcode and both lookup tables are constants computed inside the design. The control sequence can therefore be changed by editing a table, with no change to the gating logic. The surrounding datapath samples `ctrl` every cycle. It keeps `opcode` stable while a lookup step is in progress.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the microaddress is loaded with 0. After reset, `uaddr` reads 0 and `ctrl` reads 0x9408.
- R2: The control word depends only on the microaddress: 0→0x9408, 1→0x0018, 2→0x0014, 3→0x3000, 4→0x0202, 5→0x2800, 6→0x0044, 7→0x0003, 8→0x40A4, 9→0x8100.
- R3: Sequencing code 2'b11 (held by microaddresses 0, 3 and 6) loads the current microaddress plus one at the next edge.
- R4: Sequencing code 2'b00 (held by microaddresses 4, 5, 7, 8 and 9) loads microaddress 0 at the next edge.
- R5: Sequencing code 2'b01 (held by microaddress 1) loads an entry of the first table. The entries are: opcode 0x00→6, 0x02→9, 0x04→8, and both 0x23 and 0x2B→2.
- R6: Sequencing code 2'b10 (held by microaddress 2) loads an entry of the second table. The entries are: opcode 0x23→3 and 0x2B→5.
- R7: An opcode that has no entry in the table being consulted sends the sequencer to microaddress 0.
- R8: The opcode is used only on lookup steps. Changing it while the sequencer sits at an increment or fetch-return step does not alter the next microaddress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| uaddr | output | 4 | Current microaddress |
| ctrl | output | 16 | Datapath control vector of the current microinstruction |

## Verification
All 64 opcode values are swept from reset, and every microaddress and control word along each path is compared with a model built from the tables above. The sweep covers the following faults:

- A swapped lookup entry would send a load down the store path, or a branch into the jump step.
- An unlisted opcode that fell through to a stale address, instead of 0, would run a random control sequence.
- Reading the wrong table at microaddress 2 would make loads and stores diverge.

Back-to-back instructions without reset show that each fetch return lands on 0. Changing the opcode during increment steps catches a design that consults a lookup table on every cycle rather than only when the sequencing code asks for one.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W = 6;
  localparam int UA_W = 4;
  localparam int CW_W = 16;
  localparam int SC_W = 2;
  localparam int UW_W = CW_W + SC_W;

  typedef enum logic [SC_W-1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_TBL_A = 2'b01,
    SEQ_TBL_B = 2'b10,
    SEQ_STEP  = 2'b11
  } seq_code_e;

  localparam logic [OP_W-1:0] OPC_REGOP = 6'h00;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OP_W-1:0] OPC_BRNCH = 6'h04;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  // one microinstruction: control vector then sequencing code
  function automatic logic [UW_W-1:0] ucode_word(input int a);
    case (a)
      0:       return {16'h9408, SEQ_STEP};
      1:       return {16'h0018, SEQ_TBL_A};
      2:       return {16'h0014, SEQ_TBL_B};
      3:       return {16'h3000, SEQ_STEP};
      4:       return {16'h0202, SEQ_FETCH};
      5:       return {16'h2800, SEQ_FETCH};
      6:       return {16'h0044, SEQ_STEP};
      7:       return {16'h0003, SEQ_FETCH};
      8:       return {16'h40A4, SEQ_FETCH};
      9:       return {16'h8100, SEQ_FETCH};
      default: return '0;
    endcase
  endfunction

  function automatic logic [UA_W-1:0] tbl_a_lookup(input logic [OP_W-1:0] op);
    case (op)
      OPC_REGOP:           return 4'd6;
      OPC_JUMP:            return 4'd9;
      OPC_BRNCH:           return 4'd8;
      OPC_LOAD, OPC_STORE: return 4'd2;
      default:             return 4'd0;
    endcase
  endfunction

  function automatic logic [UA_W-1:0] tbl_b_lookup(input logic [OP_W-1:0] op);
    case (op)
      OPC_LOAD:  return 4'd3;
      OPC_STORE: return 4'd5;
      default:   return 4'd0;
    endcase
  endfunction

  function automatic logic [UA_W-1:0] step_addr(input logic [UA_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/useq_upc.sv
module useq_upc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cur,
  output logic [W-1:0] inc
);
  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign inc = cur + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int DW = UW_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign mem[i] = DW'(ucode_word(i));
  end

  assign word = mem[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int STAGE = 1,
  parameter int OW    = OP_W,
  parameter int AW    = UA_W
) (
  input  logic [OW-1:0] op,
  output logic [AW-1:0] tgt
);
  if (STAGE == 1) begin : g_first
    assign tgt = AW'(tbl_a_lookup(OP_W'(op)));
  end else begin : g_second
    assign tgt = AW'(tbl_b_lookup(OP_W'(op)));
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int AW  = UA_W,
  parameter int CW  = CW_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  uaddr,
  output logic [CW-1:0]  ctrl
);
  localparam int WW = CW + SC_W;

  logic [WW-1:0]   uword;
  logic [SC_W-1:0] sel_code;
  logic [AW-1:0]   inc_addr;
  logic [AW-1:0]   tbl_a_addr;
  logic [AW-1:0]   tbl_b_addr;
  logic [AW-1:0]   next_addr;

  useq_upc #(.W(AW)) u_upc (
    .clk(clk), .rst(rst), .nxt(next_addr), .cur(uaddr), .inc(inc_addr)
  );

  useq_store #(.AW(AW), .DW(WW)) u_store (
    .addr(uaddr), .word(uword)
  );

  useq_dispatch #(.STAGE(1), .OW(OPW), .AW(AW)) u_tbl_a (
    .op(opcode), .tgt(tbl_a_addr)
  );

  useq_dispatch #(.STAGE(2), .OW(OPW), .AW(AW)) u_tbl_b (
    .op(opcode), .tgt(tbl_b_addr)
  );

  assign ctrl     = uword[WW-1:SC_W];
  assign sel_code = uword[SC_W-1:0];

  always_comb begin
    case (sel_code)
      SEQ_STEP:  next_addr = inc_addr;
      SEQ_TBL_A: next_addr = tbl_a_addr;
      SEQ_TBL_B: next_addr = tbl_b_addr;
      default:   next_addr = '0;
    endcase
  end
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] uaddr,
  input logic [1:0] sel_code
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> uaddr == 4'd0); // R1

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    sel_code == 2'b11 |=> uaddr == $past(uaddr) + 4'd1); // R3

  AST_FETCH_RET: assert property (@(posedge clk) disable iff (rst)
    sel_code == 2'b00 |=> uaddr == 4'd0); // R4

  AST_TBL_A_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_code == 2'b01 |=> uaddr inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9}); // R5

  AST_TBL_B_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_code == 2'b10 |=> uaddr inside {4'd0, 4'd3, 4'd5}); // R6

  AST_UNLISTED_OP: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b10 && !(opcode inside {6'h23, 6'h2B})) |=> uaddr == 4'd0); // R7

  AST_REACH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    uaddr <= 4'd9); // R2
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .uaddr(uaddr), .sel_code(sel_code)
);

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [3:0] uaddr;
  logic [15:0] ctrl;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  useq_ctrl dut_i (.clk(clk), .rst(rst), .opcode(opcode), .uaddr(uaddr), .ctrl(ctrl));

  // R2 control words, expressed as a lookup by address
  function automatic logic [15:0] want_ctrl(input logic [3:0] a);
    logic [15:0] t [10] = '{16'h9408, 16'h0018, 16'h0014, 16'h3000, 16'h0202,
                           16'h2800, 16'h0044, 16'h0003, 16'h40A4, 16'h8100};
    return (a < 4'd10) ? t[a] : 16'h0000;
  endfunction

  // successor from R3..R7
  function automatic logic [3:0] want_next(input logic [3:0] a, input logic [5:0] op);
    if (a == 4'd0 || a == 4'd3 || a == 4'd6) return a + 4'd1;
    if (a == 4'd1) begin
      if (op == 6'h00) return 4'd6;
      if (op == 6'h02) return 4'd9;
      if (op == 6'h04) return 4'd8;
      if (op == 6'h23 || op == 6'h2B) return 4'd2;
      return 4'd0;
    end
    if (a == 4'd2) return (op == 6'h23) ? 4'd3 : (op == 6'h2B) ? 4'd5 : 4'd0;
    return 4'd0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R1 uaddr", {12'h0, uaddr}, 16'h0000);
    check("R1 ctrl", ctrl, 16'h9408);
  endtask

  // advance one edge, compare against model
  task automatic step_check(inout logic [3:0] exp_a, input string req);
    exp_a = want_next(exp_a, opcode);
    @(posedge clk); @(negedge clk);
    check(req, {12'h0, uaddr}, {12'h0, exp_a});
    check("R2 ctrl", ctrl, want_ctrl(exp_a));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] ea;
    // R5 R6 R7 sweep of every opcode from reset
    for (int op = 0; op < 64; op++) begin
      opcode = 6'(op);
      do_reset();
      ea = 4'd0;
      for (int s = 0; s < 6; s++) begin
        step_check(ea, "R3/R5/R6/R7 path");
        if (ea == 4'd0) break;
      end
    end

    // R4 back-to-back instructions without reset
    do_reset();
    ea = 4'd0;
    for (int k = 0; k < 6; k++) begin
      logic [5:0] seq_op [6] = '{6'h00, 6'h23, 6'h04, 6'h02, 6'h2B, 6'h3F};
      opcode = seq_op[k];
      do begin
        step_check(ea, "R4 chain");
      end while (ea != 4'd0);
    end

    // R8 opcode changes during non-lookup steps
    opcode = 6'h23;
    do_reset();
    opcode = 6'h3F;
    @(posedge clk); @(negedge clk);
    check("R8 fetch ignores opcode", {12'h0, uaddr}, 16'h0001);
    opcode = 6'h23;
    @(posedge clk); @(negedge clk);
    check("R8 load to addr calc", {12'h0, uaddr}, 16'h0002);
    @(posedge clk); @(negedge clk);
    check("R8 load read step", {12'h0, uaddr}, 16'h0003);
    opcode = 6'h2B;
    @(posedge clk); @(negedge clk);
    check("R8 increment ignores opcode", {12'h0, uaddr}, 16'h0004);
    opcode = 6'h00;
    @(posedge clk); @(negedge clk);
    check("R8 fetch return ignores opcode", {12'h0, uaddr}, 16'h0000);

    // R1 reset in mid program
    opcode = 6'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 mid pre", {12'h0, uaddr}, 16'h0006);
    do_reset();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule